// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours in 24-hour form, a day-of-week marker, date, month and a two-digit year that stands for 2000 to 2099. Every `DIV_COUNT` pulses of a 32.768 kHz reference tick (the tick itself comes from outside, one system-clock cycle wide) it advances the time by one second. The advance carries through every field in turn: seconds into minutes, minutes into hours, hours into the date and the day-of-week, the date into the month, and the month into the year. Month lengths follow the calendar, and February gains a 29th day in any year divisible by four.

Software sets and reads each field through a flat register port with seven addresses. A write to the seconds field also restarts the sub-second divider, so the first advance after that write comes a full second later. The `hold` input freezes timekeeping without losing any state. A synchronous reset loads midnight on the first of January of year 00 and keeps the clock still while it is asserted. Two one-cycle strobes, one per second and one per minute rollover, are meant to feed interrupt logic outside the block.

Top module: `rtc_calendar`

## Requirements
- R1: While `rst` is high at a clock edge, the fields become seconds 00, minutes 00, hours 00, week 8'h01, date 01, month 01 and year 00, and the divider clears. Reference pulses that arrive during reset advance nothing.
- R2: Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 week, 4 date, 5 month, 6 year. Address 7 reads 8'h00 and ignores writes. `rd_data` shows the field at `rd_addr` one clock after the address is presented.
- R3: The time advances by one second on the clock edge that takes in the `DIV_COUNT`-th counted reference pulse. `sec_stb` is high for exactly the one cycle in which the advanced value is first visible.
- R4: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. `min_stb` rises together with `sec_stb` only when the seconds roll over.
- R5: Hours count 00 to 23 in BCD and roll from 23 to 00, which carries one day.
- R6: The week field is one-hot in bits 6..0. On a day carry it rotates toward the MSB, and bit 6 wraps to bit 0.
- R7: The date rolls to 01 after the month's last day: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for 04, 06, 09 and 11, and 28 for February, or 29 when the BCD year read as decimal is divisible by four (this includes 00).
- R8: The month rolls from 12 to 01 and carries into the year. The year counts in BCD and wraps from 99 to 00.
- R9: A write to address 0 clears the sub-second divider. The next advance needs a full `DIV_COUNT` pulses after that write.
- R10: While `hold` is high, reference pulses are not counted. The fields, the divider and the strobes stay as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| hold | input | 1 | Freezes timekeeping while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | BCD write data |
| rd_addr | input | 3 | Field address for a read |
| rd_data | output | 8 | Registered read data |
| sec_stb | output | 1 | One-cycle pulse on each second advance |
| min_stb | output | 1 | One-cycle pulse on each seconds rollover |

## Verification
The properties assume that software writes only legal BCD values: each field within its own range, hours no higher than 23, and a week value with exactly one bit set. They also assume `DIV_COUNT` is at least two. Under those conditions the hour range, the one-hot week field and the spacing of the strobes all hold. The bench keeps within these limits: every vector loads a valid calendar date and a one-hot weekday, and all writes happen while the reference tick is low. The vectors target each carry boundary, including BCD digit carries, leap and non-leap Februaries, and the year wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    A_SEC = 3'd0, A_MIN = 3'd1, A_HR = 3'd2, A_WK = 3'd3,
    A_DAY = 3'd4, A_MON = 3'd5, A_YR = 3'd6, A_SPARE = 3'd7
  } field_addr_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] wk;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] yr;
  } tod_t;

  localparam logic [7:0] MASK_SEC = 8'h7F;
  localparam logic [7:0] MASK_MIN = 8'h7F;
  localparam logic [7:0] MASK_HR  = 8'h3F;
  localparam logic [7:0] MASK_WK  = 8'h7F;
  localparam logic [7:0] MASK_DAY = 8'h3F;
  localparam logic [7:0] MASK_MON = 8'h1F;
  localparam logic [7:0] MASK_YR  = 8'hFF;

  localparam tod_t TOD_INIT = '{sec: 8'h00, min: 8'h00, hr: 8'h00, wk: 8'h01,
                                day: 8'h01, mon: 8'h01, yr: 8'h00};

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 is 2 modulo 4, so tens*2 + ones has the same remainder as the year.
  function automatic logic is_leap(input logic [7:0] y);
    logic [4:0] r;
    r = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (r[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic hold,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt;
  logic          count_en;

  assign count_en = ref_tick && !hold && !rst && !clr;
  assign sec_tick = count_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (count_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output tod_t       tod,
  output logic       sec_stb,
  output logic       min_stb
);
  tod_t nxt;
  logic sec_wrap;

  assign sec_wrap = (tod.sec == 8'h59);

  always_comb begin
    nxt = tod;
    if (sec_tick) begin
      nxt.sec = sec_wrap ? 8'h00 : bcd_inc(tod.sec);
      if (sec_wrap) begin
        nxt.min = (tod.min == 8'h59) ? 8'h00 : bcd_inc(tod.min);
        if (tod.min == 8'h59) begin
          nxt.hr = (tod.hr == 8'h23) ? 8'h00 : bcd_inc(tod.hr);
          if (tod.hr == 8'h23) begin
            nxt.wk = {1'b0, tod.wk[5:0], tod.wk[6]};
            if (tod.day == month_end(tod.mon, tod.yr)) begin
              nxt.day = 8'h01;
              nxt.mon = (tod.mon == 8'h12) ? 8'h01 : bcd_inc(tod.mon);
              if (tod.mon == 8'h12)
                nxt.yr = (tod.yr == 8'h99) ? 8'h00 : bcd_inc(tod.yr);
            end else begin
              nxt.day = bcd_inc(tod.day);
            end
          end
        end
      end
    end
    // A software write to a field overrides its advanced value.
    if (wr_en) begin
      case (field_addr_e'(wr_addr))
        A_SEC:   nxt.sec = wr_data & MASK_SEC;
        A_MIN:   nxt.min = wr_data & MASK_MIN;
        A_HR:    nxt.hr  = wr_data & MASK_HR;
        A_WK:    nxt.wk  = wr_data & MASK_WK;
        A_DAY:   nxt.day = wr_data & MASK_DAY;
        A_MON:   nxt.mon = wr_data & MASK_MON;
        A_YR:    nxt.yr  = wr_data & MASK_YR;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod     <= TOD_INIT;
      sec_stb <= 1'b0;
      min_stb <= 1'b0;
    end else begin
      tod     <= nxt;
      sec_stb <= sec_tick;
      min_stb <= sec_tick && sec_wrap;
    end
  end
endmodule

// File: rtl/rtc_readport.sv
module rtc_readport
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tod_t       tod,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (field_addr_e'(rd_addr))
        A_SEC:   rd_data <= tod.sec;
        A_MIN:   rd_data <= tod.min;
        A_HR:    rd_data <= tod.hr;
        A_WK:    rd_data <= tod.wk;
        A_DAY:   rd_data <= tod.day;
        A_MON:   rd_data <= tod.mon;
        A_YR:    rd_data <= tod.yr;
        default: rd_data <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_stb,
  output logic       min_stb
);
  tod_t       tod;
  logic       sec_tick;
  logic       sec_clr;
  logic [7:0] sec_q;
  logic [7:0] hr_q;
  logic [7:0] wk_q;

  assign sec_clr = wr_en && (wr_addr == 3'd0);
  assign sec_q   = tod.sec;
  assign hr_q    = tod.hr;
  assign wk_q    = tod.wk;

  rtc_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .hold(hold),
    .clr(sec_clr), .sec_tick(sec_tick)
  );

  rtc_timekeeper u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tod(tod),
    .sec_stb(sec_stb), .min_stb(min_stb)
  );

  rtc_readport u_rd (
    .clk(clk), .rst(rst), .tod(tod), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold,
  input logic       sec_stb,
  input logic       min_stb,
  input logic [7:0] sec_q,
  input logic [7:0] hr_q,
  input logic [7:0] wk_q
);
  // R4: the minute strobe only comes with a second strobe
  a_r4_min_with_sec: assert property (@(posedge clk) disable iff (rst)
    min_stb |-> sec_stb);

  // R4: after a minute rollover the seconds read 00
  a_r4_min_sec_zero: assert property (@(posedge clk) disable iff (rst)
    min_stb |-> (sec_q == 8'h00));

  // R3: the second strobe lasts a single cycle
  a_r3_stb_single: assert property (@(posedge clk) disable iff (rst)
    sec_stb |=> !sec_stb);

  // R10: no advance is reported after a held cycle
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold |=> !sec_stb);

  // R5: hours stay within 00..23
  a_r5_hour_range: assert property (@(posedge clk) disable iff (rst)
    hr_q <= 8'h23);

  // R6: exactly one weekday bit is set
  a_r6_week_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(wk_q) == 1);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .hold(hold), .sec_stb(sec_stb), .min_stb(min_stb),
  .sec_q(sec_q), .hr_q(hr_q), .wk_q(wk_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  import rtc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NV = 12;

  typedef struct packed {
    tod_t start;
    tod_t expect_t;
    logic mstb;
  } vec_t;

  // start {sec,min,hr,wk,day,mon,yr} -> expected after one second, minute strobe
  localparam vec_t VECS [NV] = '{
    '{'{8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, '{8'h01,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, 1'b0},
    '{'{8'h59,8'h12,8'h05,8'h02,8'h15,8'h06,8'h30}, '{8'h00,8'h13,8'h05,8'h02,8'h15,8'h06,8'h30}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h40,8'h31,8'h12,8'h99}, '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h24}, '{8'h00,8'h00,8'h00,8'h08,8'h29,8'h02,8'h24}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h23}, '{8'h00,8'h00,8'h00,8'h08,8'h01,8'h03,8'h23}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h10,8'h29,8'h02,8'h00}, '{8'h00,8'h00,8'h00,8'h20,8'h01,8'h03,8'h00}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h20,8'h30,8'h04,8'h45}, '{8'h00,8'h00,8'h00,8'h40,8'h01,8'h05,8'h45}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h01,8'h30,8'h01,8'h45}, '{8'h00,8'h00,8'h00,8'h02,8'h31,8'h01,8'h45}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h02,8'h31,8'h12,8'h19}, '{8'h00,8'h00,8'h00,8'h04,8'h01,8'h01,8'h20}, 1'b1},
    '{'{8'h59,8'h59,8'h09,8'h08,8'h11,8'h07,8'h33}, '{8'h00,8'h00,8'h10,8'h08,8'h11,8'h07,8'h33}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h08,8'h30,8'h09,8'h50}, '{8'h00,8'h00,8'h00,8'h10,8'h01,8'h10,8'h50}, 1'b1},
    '{'{8'h59,8'h59,8'h23,8'h40,8'h28,8'h02,8'h10}, '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h03,8'h10}, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic       hold = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_stb, min_stb;

  int n_tests = 0;
  int n_fail = 0;
  logic s_stb, m_stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar #(.DIV_COUNT(DIV)) u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .hold(hold),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_stb(sec_stb), .min_stb(min_stb)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic load(input tod_t t);
    wr(3'd1, t.min); wr(3'd2, t.hr); wr(3'd3, t.wk);
    wr(3'd4, t.day); wr(3'd5, t.mon); wr(3'd6, t.yr); wr(3'd0, t.sec);
  endtask

  task automatic read_all(output tod_t t);
    rd(3'd0, t.sec); rd(3'd1, t.min); rd(3'd2, t.hr); rd(3'd3, t.wk);
    rd(3'd4, t.day); rd(3'd5, t.mon); rd(3'd6, t.yr);
  endtask

  // Pulse the reference n times; strobes are sampled after the last pulse.
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
    end
    @(negedge clk); ref_tick = 1'b0;
    s_stb = sec_stb; m_stb = min_stb;
  endtask

  task automatic compare(input string tag, input tod_t act, input tod_t exp);
    check({tag, " R4"}, "seconds", act.sec, exp.sec);
    check({tag, " R4"}, "minutes", act.min, exp.min);
    check({tag, " R5"}, "hours", act.hr, exp.hr);
    check({tag, " R6"}, "week", act.wk, exp.wk);
    check({tag, " R7"}, "date", act.day, exp.day);
    check({tag, " R8"}, "month", act.mon, exp.mon);
    check({tag, " R8"}, "year", act.yr, exp.yr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tod_t got;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    read_all(got);
    compare("R1 reset", got, TOD_INIT);
    check("R1", "sec_stb after reset", {7'd0, sec_stb}, 8'h00);

    // Vector table: one second advance from each start point
    for (int i = 0; i < NV; i++) begin
      load(VECS[i].start);
      pulses(DIV);
      check("R3", "sec_stb on advance", {7'd0, s_stb}, 8'h01);
      check("R4", "min_stb on advance", {7'd0, m_stb}, {7'd0, VECS[i].mstb});
      @(negedge clk);
      check("R3", "sec_stb one cycle", {7'd0, sec_stb}, 8'h00);
      read_all(got);
      compare($sformatf("vec%0d", i), got, VECS[i].expect_t);
    end

    // R3: DIV-1 pulses do not advance
    load('{8'h10,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00});
    pulses(DIV - 1);
    check("R3", "no strobe before last pulse", {7'd0, s_stb}, 8'h00);
    rd(3'd0, v); check("R3", "seconds before last pulse", v, 8'h10);

    // R9: seconds write restarts the divider
    wr(3'd0, 8'h20);
    pulses(DIV - 1);
    rd(3'd0, v); check("R9", "seconds after restart", v, 8'h20);
    pulses(1);
    check("R9", "strobe after full second", {7'd0, s_stb}, 8'h01);
    rd(3'd0, v); check("R9", "seconds advanced", v, 8'h21);

    // R10: hold freezes counting
    @(negedge clk); hold = 1'b1;
    pulses(DIV * 2);
    check("R10", "strobe while held", {7'd0, s_stb}, 8'h00);
    rd(3'd0, v); check("R10", "seconds while held", v, 8'h21);
    @(negedge clk); hold = 1'b0;
    pulses(DIV);
    rd(3'd0, v); check("R10", "seconds after release", v, 8'h22);

    // R2: spare address ignores writes and reads zero
    wr(3'd7, 8'hA5);
    rd(3'd7, v); check("R2", "spare address", v, 8'h00);
    read_all(got);
    compare("R2 spare write", got, '{8'h22,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00});
    // R2: unused upper bits read zero
    wr(3'd5, 8'hF2);
    rd(3'd5, v); check("R2", "month masked", v, 8'h12);

    // R1: reset pauses counting
    load('{8'h45,8'h30,8'h12,8'h08,8'h15,8'h07,8'h55});
    @(negedge clk); rst = 1'b1;
    pulses(DIV * 2);
    check("R1", "strobe during reset", {7'd0, s_stb}, 8'h00);
    @(negedge clk); rst = 1'b0;
    read_all(got);
    compare("R1 reset pause", got, TOD_INIT);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule